// File: doc/BRIEF.md
# Address Translation Cache with Address-Space Tags

This block caches virtual-to-physical page translations for a processor's memory pipeline. Every slot holds a virtual page number, a physical page number, an 8-bit address-space identifier, a global flag and two per-privilege-mode permission masks, one for reads and one for writes. A request presents a page number and the current address-space identifier. One clock later the block reports hit or miss, the slot index and the stored fields. Slots are fully associative, and new translations land in the slot named by a rotating victim pointer.

Three slots named by the most recent array hits form a shortcut that is consulted first, newest first. A request that is served from the array, and not from the shortcut, pushes its slot onto the front of the shortcut and drops the oldest one. Any insert or flush empties the shortcut, so it can never name a slot whose contents have changed.

The command port drives a small operation decoder with five named operations: `OP_NONE` (idle), `OP_INSERT`, `OP_FLUSH_ALL`, `OP_FLUSH_LOCAL` and `OP_FLUSH_ADDR`. Every operation takes effect at the next clock edge and returns to idle unless the command is held. The transitions of the table state are:
- insert: the slot at the pointer becomes valid and the pointer advances;
- flush: the selected valid bits clear;
- any operation other than idle: the shortcut empties.

Top module: `xlat_cache`

## Requirements
- R1: After reset every slot is invalid, the victim pointer is 0 and the shortcut is empty, so every lookup misses and `rsp_valid_o` is low until the first request.
- R2: A lookup hits a slot only if the slot is valid, its page tag equals `lk_vpn_i`, and either its global flag is set or its stored identifier equals `lk_asn_i`.
- R3: The response to a request sampled at one rising edge is visible after that edge: `rsp_valid_o` is 1 in that cycle exactly when `lk_req_i` was 1, and it is 0 otherwise.
- R4: `cmd_op_i` = 1 (insert) writes `cmd_vpn_i`, `cmd_asn_i`, `ins_ppn_i`, `ins_global_i`, `ins_rd_en_i` and `ins_wr_en_i` into the slot at the pointer and marks it valid, evicting any occupant. The pointer then advances by one and wraps from DEPTH-1 to 0. No other command moves the pointer.
- R5: The three shortcut entries are checked first, newest first. A hit found there reports `rsp_mru_o` = 1 and leaves the shortcut unchanged.
- R6: A hit found only in the array moves that slot to the front of the shortcut and drops the oldest entry, unless a command is issued in the same cycle.
- R7: Any command with code 1 to 4 empties the shortcut. The next lookup after it reports `rsp_mru_o` = 0.
- R8: `cmd_op_i` = 2 invalidates every slot.
- R9: `cmd_op_i` = 3 invalidates every valid slot whose global flag is clear and keeps the global slots.
- R10: `cmd_op_i` = 4 invalidates every valid slot whose tag equals `cmd_vpn_i` and that is global or holds `cmd_asn_i`. Other slots keep their state.
- R11: A lookup issued in the same cycle as a command sees the table and shortcut as they were before that command.
- R12: When several array slots match and none is in the shortcut, the lowest slot index is reported.
- R13: A response that misses reports zero in `rsp_index_o`, `rsp_ppn_o`, `rsp_global_o`, `rsp_rd_en_o` and `rsp_wr_en_o`, and `rsp_mru_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| lk_req_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W (51) | Page number to translate |
| lk_asn_i | input | ASN_W (8) | Current address-space identifier |
| cmd_op_i | input | 3 | 0 idle, 1 insert, 2 flush all, 3 flush non-global, 4 flush by page and identifier; codes 5 to 7 act as idle |
| cmd_vpn_i | input | VPN_W (51) | Page number for insert or flush by page |
| cmd_asn_i | input | ASN_W (8) | Identifier for insert or flush by page |
| ins_ppn_i | input | PPN_W (30) | Physical page to insert |
| ins_global_i | input | 1 | Global flag to insert |
| ins_rd_en_i | input | MODES (4) | Read permission per mode to insert |
| ins_wr_en_i | input | MODES (4) | Write permission per mode to insert |
| rsp_valid_o | output | 1 | Response present |
| rsp_hit_o | output | 1 | Translation found |
| rsp_mru_o | output | 1 | Hit served from the shortcut |
| rsp_index_o | output | log2(DEPTH) (6) | Slot that hit |
| rsp_ppn_o | output | PPN_W (30) | Physical page of the hit |
| rsp_global_o | output | 1 | Global flag of the hit |
| rsp_rd_en_o | output | MODES (4) | Read permission mask of the hit |
| rsp_wr_en_o | output | MODES (4) | Write permission mask of the hit |

## Verification
Every result of this block appears exactly one edge after its cause. A response reflects the table as it stood at the edge that sampled the request. A command changes the table, the pointer and the shortcut at that same edge, so its effect shows in the response to the request made in the following cycle. The bench drives all inputs on the falling edge and updates its reference model in the same order: the response is taken from the old state first, then the command is applied. It compares all response outputs on the next falling edge. This is how the same-cycle cases (R11) and the shortcut promotion order (R6, R7) are checked without any guessing about timing.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // Command codes on cmd_op_i
    typedef enum logic [2:0] {
        OP_NONE        = 3'd0,
        OP_INSERT      = 3'd1,
        OP_FLUSH_ALL   = 3'd2,
        OP_FLUSH_LOCAL = 3'd3,
        OP_FLUSH_ADDR  = 3'd4
    } op_e;

endpackage

// File: rtl/xlat_match.sv
// Per-slot hit detection: valid, tag equal, and global or identifier equal.
module xlat_match #(
    parameter int DEPTH = 64,
    parameter int VPN_W = 51,
    parameter int ASN_W = 8
) (
    input  logic [DEPTH-1:0]            vld_i,
    input  logic [DEPTH-1:0][VPN_W-1:0] tag_i,
    input  logic [DEPTH-1:0][ASN_W-1:0] asn_i,
    input  logic [DEPTH-1:0]            glb_i,
    input  logic [VPN_W-1:0]            qry_vpn_i,
    input  logic [ASN_W-1:0]            qry_asn_i,
    output logic [DEPTH-1:0]            hit_o
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign hit_o[g] = vld_i[g] && (tag_i[g] == qry_vpn_i) &&
                          (glb_i[g] || (asn_i[g] == qry_asn_i));
    end

endmodule

// File: rtl/xlat_first.sv
// Lowest-index set bit of a vector.
module xlat_first #(
    parameter int DEPTH = 64,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] vec_i,
    output logic             found_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/xlat_mru.sv
// Shortcut of the most recently promoted slots; slot 0 is the newest.
module xlat_mru #(
    parameter int DEPTH = 64,
    parameter int SLOTS = 3,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [DEPTH-1:0] hit_vec_i,
    input  logic             promote_i,
    input  logic [IDX_W-1:0] promote_idx_i,
    input  logic             clear_i,
    output logic             mru_hit_o,
    output logic [IDX_W-1:0] mru_idx_o
);

    logic [SLOTS-1:0]            sv_q;
    logic [SLOTS-1:0][IDX_W-1:0] si_q;

    // Newest entry wins: scan from the oldest down so slot 0 is applied last
    always_comb begin
        mru_hit_o = 1'b0;
        mru_idx_o = '0;
        for (int s = SLOTS - 1; s >= 0; s--) begin
            if (sv_q[s] && hit_vec_i[si_q[s]]) begin
                mru_hit_o = 1'b1;
                mru_idx_o = si_q[s];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sv_q <= '0;
            si_q <= '0;
        end else if (clear_i) begin
            sv_q <= '0;
        end else if (promote_i) begin
            sv_q <= {sv_q[SLOTS-2:0], 1'b1};
            si_q <= {si_q[SLOTS-2:0], promote_idx_i};
        end
    end

    // R7: a clear leaves no entry behind
    a_r7_mru_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (sv_q == '0));

    // R6: entries fill from the front, so valid bits stay contiguous
    a_r6_mru_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((sv_q + 1'b1) & sv_q) == '0);

    // R6: a promotion without clear puts the promoted slot in front
    a_r6_mru_front: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (promote_i && !clear_i) |=> (sv_q[0] && si_q[0] == $past(promote_idx_i)));

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
    parameter int DEPTH = 64,
    parameter int VPN_W = 51,
    parameter int PPN_W = 30,
    parameter int ASN_W = 8,
    parameter int MODES = 4,
    parameter int MRU_SLOTS = 3,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             lk_req_i,
    input  logic [VPN_W-1:0] lk_vpn_i,
    input  logic [ASN_W-1:0] lk_asn_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [VPN_W-1:0] cmd_vpn_i,
    input  logic [ASN_W-1:0] cmd_asn_i,
    input  logic [PPN_W-1:0] ins_ppn_i,
    input  logic             ins_global_i,
    input  logic [MODES-1:0] ins_rd_en_i,
    input  logic [MODES-1:0] ins_wr_en_i,
    output logic             rsp_valid_o,
    output logic             rsp_hit_o,
    output logic             rsp_mru_o,
    output logic [IDX_W-1:0] rsp_index_o,
    output logic [PPN_W-1:0] rsp_ppn_o,
    output logic             rsp_global_o,
    output logic [MODES-1:0] rsp_rd_en_o,
    output logic [MODES-1:0] rsp_wr_en_o
);

    import xlat_pkg::*;

    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    // Table state
    logic [DEPTH-1:0]            vld_q, vld_d;
    logic [DEPTH-1:0][VPN_W-1:0] tag_q;
    logic [DEPTH-1:0][ASN_W-1:0] asn_q;
    logic [DEPTH-1:0][PPN_W-1:0] ppn_q;
    logic [DEPTH-1:0]            glb_q;
    logic [DEPTH-1:0][MODES-1:0] rd_q;
    logic [DEPTH-1:0][MODES-1:0] wr_q;
    logic [IDX_W-1:0]            ptr_q, ptr_d;

    op_e              op;
    logic             wr_en;
    logic             mru_clear;
    logic [DEPTH-1:0] lk_hit_vec;
    logic [DEPTH-1:0] fl_hit_vec;
    logic             arr_found;
    logic [IDX_W-1:0] arr_idx;
    logic             mru_hit;
    logic [IDX_W-1:0] mru_idx;
    logic             sel_hit;
    logic [IDX_W-1:0] sel_idx;
    logic             promote;

    assign op = op_e'(cmd_op_i);

    // Match for lookups
    xlat_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_match (
        .vld_i     (vld_q),
        .tag_i     (tag_q),
        .asn_i     (asn_q),
        .glb_i     (glb_q),
        .qry_vpn_i (lk_vpn_i),
        .qry_asn_i (lk_asn_i),
        .hit_o     (lk_hit_vec)
    );

    // Match for selective flush
    xlat_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
        .vld_i     (vld_q),
        .tag_i     (tag_q),
        .asn_i     (asn_q),
        .glb_i     (glb_q),
        .qry_vpn_i (cmd_vpn_i),
        .qry_asn_i (cmd_asn_i),
        .hit_o     (fl_hit_vec)
    );

    xlat_first #(.DEPTH(DEPTH)) u_first (
        .vec_i   (lk_hit_vec),
        .found_o (arr_found),
        .idx_o   (arr_idx)
    );

    xlat_mru #(.DEPTH(DEPTH), .SLOTS(MRU_SLOTS)) u_mru (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .hit_vec_i     (lk_hit_vec),
        .promote_i     (promote),
        .promote_idx_i (arr_idx),
        .clear_i       (mru_clear),
        .mru_hit_o     (mru_hit),
        .mru_idx_o     (mru_idx)
    );

    assign sel_hit = mru_hit | arr_found;
    assign sel_idx = mru_hit ? mru_idx : arr_idx;
    assign promote = lk_req_i & ~mru_hit & arr_found;

    // Operation decoder: next table state
    always_comb begin
        vld_d     = vld_q;
        ptr_d     = ptr_q;
        wr_en     = 1'b0;
        mru_clear = 1'b1;
        unique case (op)
            OP_NONE: begin
                mru_clear = 1'b0;
            end
            OP_INSERT: begin
                vld_d[ptr_q] = 1'b1;
                wr_en        = 1'b1;
                ptr_d        = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
            end
            OP_FLUSH_ALL: begin
                vld_d = '0;
            end
            OP_FLUSH_LOCAL: begin
                vld_d = vld_q & glb_q;
            end
            OP_FLUSH_ADDR: begin
                vld_d = vld_q & ~fl_hit_vec;
            end
            default: begin
                mru_clear = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            vld_q <= '0;
            ptr_q <= '0;
        end else begin
            vld_q <= vld_d;
            ptr_q <= ptr_d;
        end
    end

    // Slot payload, written only by insert
    always_ff @(posedge clk_i) begin
        if (wr_en) begin
            tag_q[ptr_q] <= cmd_vpn_i;
            asn_q[ptr_q] <= cmd_asn_i;
            ppn_q[ptr_q] <= ins_ppn_i;
            glb_q[ptr_q] <= ins_global_i;
            rd_q[ptr_q]  <= ins_rd_en_i;
            wr_q[ptr_q]  <= ins_wr_en_i;
        end
    end

    // Registered response
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rsp_valid_o  <= 1'b0;
            rsp_hit_o    <= 1'b0;
            rsp_mru_o    <= 1'b0;
            rsp_index_o  <= '0;
            rsp_ppn_o    <= '0;
            rsp_global_o <= 1'b0;
            rsp_rd_en_o  <= '0;
            rsp_wr_en_o  <= '0;
        end else begin
            rsp_valid_o  <= lk_req_i;
            rsp_hit_o    <= lk_req_i & sel_hit;
            rsp_mru_o    <= lk_req_i & mru_hit;
            rsp_index_o  <= (lk_req_i && sel_hit) ? sel_idx : '0;
            rsp_ppn_o    <= (lk_req_i && sel_hit) ? ppn_q[sel_idx] : '0;
            rsp_global_o <= lk_req_i && sel_hit && glb_q[sel_idx];
            rsp_rd_en_o  <= (lk_req_i && sel_hit) ? rd_q[sel_idx] : '0;
            rsp_wr_en_o  <= (lk_req_i && sel_hit) ? wr_q[sel_idx] : '0;
        end
    end

    // R3: one response per request, one edge later
    a_r3_rsp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lk_req_i |=> rsp_valid_o);
    a_r3_no_spurious_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !lk_req_i |=> !rsp_valid_o);

    // R4: pointer steps with wrap on insert and holds otherwise
    a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_INSERT) |=>
            (ptr_q == (($past(ptr_q) == LAST) ? IDX_W'(0) : IDX_W'($past(ptr_q) + 1'b1))));
    a_r4_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op != OP_INSERT) |=> $stable(ptr_q));

    // R8: flush all leaves nothing valid
    a_r8_flush_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_FLUSH_ALL) |=> (vld_q == '0));

    // R9: flush non-global leaves only global slots
    a_r9_flush_local: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_FLUSH_LOCAL) |=> ((vld_q & ~glb_q) == '0));

    // R5: a shortcut response is always a hit
    a_r5_mru_is_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsp_mru_o |-> rsp_hit_o);

    // R13: a miss carries no payload
    a_r13_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !rsp_hit_o) |->
            (rsp_index_o == '0 && rsp_ppn_o == '0 && !rsp_global_o &&
             rsp_rd_en_o == '0 && rsp_wr_en_o == '0 && !rsp_mru_o));

endmodule

// File: tb/xlat_cache_tb.sv
`timescale 1ns/1ps
module xlat_cache_tb;

    localparam int D = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        lk_req;
    logic [50:0] lk_vpn;
    logic [7:0]  lk_asn;
    logic [2:0]  cmd_op;
    logic [50:0] cmd_vpn;
    logic [7:0]  cmd_asn;
    logic [29:0] ins_ppn;
    logic        ins_glb;
    logic [3:0]  ins_rd;
    logic [3:0]  ins_wr;
    logic        rsp_valid, rsp_hit, rsp_mru, rsp_glb;
    logic [5:0]  rsp_idx;
    logic [29:0] rsp_ppn;
    logic [3:0]  rsp_rd, rsp_wr;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    xlat_cache u_dut (
        .clk_i(clk), .rst_ni(rst_n),
        .lk_req_i(lk_req), .lk_vpn_i(lk_vpn), .lk_asn_i(lk_asn),
        .cmd_op_i(cmd_op), .cmd_vpn_i(cmd_vpn), .cmd_asn_i(cmd_asn),
        .ins_ppn_i(ins_ppn), .ins_global_i(ins_glb),
        .ins_rd_en_i(ins_rd), .ins_wr_en_i(ins_wr),
        .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_mru_o(rsp_mru),
        .rsp_index_o(rsp_idx), .rsp_ppn_o(rsp_ppn), .rsp_global_o(rsp_glb),
        .rsp_rd_en_o(rsp_rd), .rsp_wr_en_o(rsp_wr)
    );

    // Reference model
    logic        m_vld [D];
    logic [50:0] m_vpn [D];
    logic [7:0]  m_asn [D];
    logic [29:0] m_ppn [D];
    logic        m_glb [D];
    logic [3:0]  m_rd  [D];
    logic [3:0]  m_wr  [D];
    int          m_ptr;
    int          m_si [3];
    logic        m_sv [3];

    function automatic bit m_match(int i, logic [50:0] v, logic [7:0] a);
        return m_vld[i] && (m_vpn[i] == v) && (m_glb[i] || (m_asn[i] == a));
    endfunction

    function automatic logic [47:0] actual();
        return {rsp_valid, rsp_hit, rsp_mru, rsp_idx, rsp_ppn, rsp_glb, rsp_rd, rsp_wr};
    endfunction

    task automatic check(input logic [47:0] exp, input string tag);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, actual(), exp);
        end
    endtask

    // One cycle: compute expectation from old model state, update model,
    // drive at falling edge, compare at next falling edge.
    task automatic step(input logic req, input logic [50:0] lv, input logic [7:0] la,
                        input logic [2:0] op, input logic [50:0] cv, input logic [7:0] ca,
                        input logic [29:0] pp, input logic g, input logic [3:0] rd,
                        input logic [3:0] wr, input string tag);
        logic [47:0] exp;
        bit found, from_mru, promote;
        int idx;
        exp = '0; found = 0; from_mru = 0; promote = 0; idx = 0;
        if (req) begin
            for (int s = 0; s < 3; s++)
                if (!found && m_sv[s] && m_match(m_si[s], lv, la)) begin
                    found = 1; from_mru = 1; idx = m_si[s];
                end
            for (int i = 0; i < D; i++)
                if (!found && m_match(i, lv, la)) begin
                    found = 1; promote = 1; idx = i;
                end
            if (found)
                exp = {1'b1, 1'b1, from_mru, 6'(idx), m_ppn[idx], m_glb[idx], m_rd[idx], m_wr[idx]};
            else
                exp = {1'b1, 47'd0};
        end
        if (op >= 3'd1 && op <= 3'd4) begin
            for (int s = 0; s < 3; s++) m_sv[s] = 0;
        end else if (promote) begin
            m_si[2] = m_si[1]; m_sv[2] = m_sv[1];
            m_si[1] = m_si[0]; m_sv[1] = m_sv[0];
            m_si[0] = idx;     m_sv[0] = 1;
        end
        case (op)
            3'd1: begin
                m_vld[m_ptr] = 1; m_vpn[m_ptr] = cv; m_asn[m_ptr] = ca;
                m_ppn[m_ptr] = pp; m_glb[m_ptr] = g; m_rd[m_ptr] = rd; m_wr[m_ptr] = wr;
                m_ptr = (m_ptr == D - 1) ? 0 : m_ptr + 1;
            end
            3'd2: for (int i = 0; i < D; i++) m_vld[i] = 0;
            3'd3: for (int i = 0; i < D; i++) if (!m_glb[i]) m_vld[i] = 0;
            3'd4: for (int i = 0; i < D; i++) if (m_match(i, cv, ca)) m_vld[i] = 0;
            default: ;
        endcase
        lk_req = req; lk_vpn = lv; lk_asn = la; cmd_op = op; cmd_vpn = cv;
        cmd_asn = ca; ins_ppn = pp; ins_glb = g; ins_rd = rd; ins_wr = wr;
        @(posedge clk);
        @(negedge clk);
        check(exp, tag);
    endtask

    task automatic look(input logic [50:0] v, input logic [7:0] a, input string tag);
        step(1'b1, v, a, 3'd0, '0, '0, '0, 1'b0, '0, '0, tag);
    endtask

    task automatic ins(input logic [50:0] v, input logic [7:0] a, input logic [29:0] p,
                       input logic g, input string tag);
        step(1'b0, '0, '0, 3'd1, v, a, p, g, 4'h5, 4'h3, tag);
    endtask

    task automatic cmd(input logic [2:0] op, input logic [50:0] v, input logic [7:0] a,
                       input string tag);
        step(1'b0, '0, '0, op, v, a, '0, 1'b0, '0, '0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R3: watchdog expired, actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d2c3b4a));
        for (int i = 0; i < D; i++) begin
            m_vld[i] = 0; m_vpn[i] = '0; m_asn[i] = '0; m_ppn[i] = '0;
            m_glb[i] = 0; m_rd[i] = '0; m_wr[i] = '0;
        end
        for (int s = 0; s < 3; s++) begin m_sv[s] = 0; m_si[s] = 0; end
        m_ptr = 0;
        rst_n = 1'b0; lk_req = 0; lk_vpn = '0; lk_asn = '0; cmd_op = '0;
        cmd_vpn = '0; cmd_asn = '0; ins_ppn = '0; ins_glb = 0; ins_rd = '0; ins_wr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: quiet outputs after reset, and a miss on an empty table
        check('0, "R1");
        look(51'd0, 8'd0, "R1");

        // R2: identifier and global matching
        ins(51'h10, 8'd1, 30'h111, 1'b0, "R3");
        look(51'h10, 8'd1, "R2");
        look(51'h10, 8'd2, "R2");
        ins(51'h11, 8'd3, 30'h222, 1'b1, "R3");
        look(51'h11, 8'd9, "R2");
        // R3: no request, no response
        step(1'b0, '0, '0, 3'd0, '0, '0, '0, 1'b0, '0, '0, "R3");

        // R6 then R5: array hit promotes, repeat served from shortcut
        look(51'h10, 8'd1, "R6");
        look(51'h10, 8'd1, "R5");
        // R7: insert empties the shortcut
        ins(51'h12, 8'd1, 30'h333, 1'b0, "R3");
        look(51'h10, 8'd1, "R7");

        // R11: lookup and insert of the same page in one cycle sees old state
        step(1'b1, 51'h13, 8'd1, 3'd1, 51'h13, 8'd1, 30'h444, 1'b0, 4'hf, 4'hf, "R11");
        look(51'h13, 8'd1, "R11");

        // R12: duplicate matches report the lowest slot
        ins(51'h20, 8'd0, 30'h555, 1'b0, "R3");
        ins(51'h20, 8'd0, 30'h666, 1'b0, "R3");
        look(51'h20, 8'd0, "R12");

        // R10: flush by page and identifier
        cmd(3'd4, 51'h10, 8'd2, "R10");
        look(51'h10, 8'd1, "R10");
        cmd(3'd4, 51'h10, 8'd1, "R10");
        look(51'h10, 8'd1, "R10");
        cmd(3'd4, 51'h11, 8'd7, "R10");
        look(51'h11, 8'd3, "R10");

        // R9: flush non-global keeps global slots
        ins(51'h30, 8'd4, 30'h777, 1'b1, "R3");
        ins(51'h31, 8'd4, 30'h888, 1'b0, "R3");
        cmd(3'd3, '0, '0, "R9");
        look(51'h30, 8'd0, "R9");
        look(51'h31, 8'd4, "R9");

        // R8: flush all
        cmd(3'd2, '0, '0, "R8");
        look(51'h30, 8'd4, "R8");

        // R4: fill past the depth so the pointer wraps
        for (int k = 0; k <= D; k++)
            ins(51'h100 + 51'(k), 8'd2, 30'(k), 1'b0, "R4");
        look(51'h100, 8'd2, "R4");
        look(51'h100 + 51'(D), 8'd2, "R4");
        look(51'h101, 8'd2, "R4");
        look(51'hbad, 8'd2, "R13");

        // Random mix over a small page and identifier pool
        for (int n = 0; n < 4000; n++) begin
            int r;
            logic [2:0] op;
            r = int'($urandom % 20);
            if (r < 10 || r == 19) op = 3'd0;
            else if (r < 16) op = 3'd1;
            else op = 3'(r - 14);
            if ((n % 500) == 499) op = 3'd6; // unused code acts as idle
            step(($urandom % 4) != 0, 51'($urandom % 6), 8'($urandom % 3), op,
                 51'($urandom % 6), 8'($urandom % 3), 30'($urandom),
                 ($urandom % 4) == 0, 4'($urandom), 4'($urandom), "R2");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule